// File: doc/BRIEF.md
# DMA Channel Address and Count Register File

This block keeps the programmable transfer registers of a four-channel DMA controller. Each channel has a 16-bit start address and a 16-bit transfer count, loaded one byte at a time over an 8-bit I/O port interface. A single byte pointer, shared by all channels, decides whether a byte access reaches the low or the high half of a register. The pointer flips after every byte access, and a dedicated strobe returns it to the low half. A full 16-bit write loads a whole register in one access and leaves the pointer where it is.

Each channel also keeps a working address and a progress count. Completing a register write reloads the working address from the start address and clears the progress count. A per-channel step input then advances the progress count until it reaches the programmed length. At that point the count wraps and a terminal pulse is raised. Readback returns the working address plus the progress, or the programmed count minus the progress. An 8-bit page register per channel is reached through a scrambled offset map and extends the working address into the physical address seen by the transfer engine.

The `WORD_MODE` parameter builds the variant for a controller that moves 16-bit units. In that variant, channel ports sit on even offsets, stored addresses and counts are doubled, and readback is halved.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, all start, count, working, progress and page registers are zero and the byte pointer is 0. A read returns 0x00, `phys_addr` is 0, `xfer_len` equals one unit and `tc` is 0.
- R2: Channel ports decode as channel = `reg_port[2+W:1+W]` and register = `reg_port[W]`, where W is 1 in word mode and 0 otherwise. Register value 0 selects the address and 1 selects the count.
- R3: A byte write or a byte read with the pointer at 0 reaches bits 7:0, and with the pointer at 1 it reaches bits 15:8. Every byte access toggles the pointer. A 16-bit write (`reg_wide`=1) loads all 16 bits and does not toggle the pointer.
- R4: A high-byte write or a 16-bit write to either register of a channel loads the working address from that channel's start address and clears its progress count.
- R5: An address read returns (working address + progress) and a count read returns (start count shifted by W − progress). In both cases the value is shifted right by W, and the byte is chosen by the pointer. `rd_data` is 0x00 when `reg_rd` is low.
- R6: `ff_clr` sets the pointer to 0 on the next edge, even when a byte access happens in the same cycle.
- R7: Page offsets 1, 2, 3 and 7 write `wr_data[7:0]` to the page registers of channels 2, 3, 1 and 0 respectively. A page write to any other offset changes no register and raises `page_bad` in the same cycle.
- R8: `phys_addr` equals {page, 16'h0} OR the working address of the channel on `sel_ch`.
- R9: `xfer_len` equals (start count shifted left by W) + (1 shifted left by W) for the channel on `sel_ch`.
- R10: A `step` bit adds one unit (1 << W) to that channel's progress. When the progress would reach `xfer_len`, it wraps to 0 and the matching `tc` bit is high for one cycle after that edge. A reload in the same cycle takes priority over the step.
- R11: In word mode, a port with bit 0 set is not a channel port. Accesses to it change no register and do not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Channel register write strobe |
| reg_rd | input | 1 | Channel register read strobe |
| reg_wide | input | 1 | With `reg_wr`, write all 16 bits at once |
| reg_port | input | 3+W | Channel register port offset |
| wr_data | input | 16 | Write data; byte and page writes use bits 7:0 |
| rd_data | output | 8 | Readback byte, valid while `reg_rd` is high |
| ff_clr | input | 1 | Return the byte pointer to the low byte |
| page_wr | input | 1 | Page register write strobe |
| page_off | input | 3 | Page register offset |
| page_bad | output | 1 | Page write hit an unmapped offset |
| step | input | NCH | Per-channel progress advance |
| tc | output | NCH | Per-channel terminal-count pulse |
| sel_ch | input | log2(NCH) | Channel whose transfer address and length are shown |
| phys_addr | output | PAGE_W+16 | Physical transfer address of `sel_ch` |
| xfer_len | output | 17+W | Transfer length of `sel_ch` in bytes |

## Verification
On every cycle, the assertions check how the byte pointer moves: it toggles on each byte access, holds otherwise, and clears with priority. They also check that a terminal pulse only follows a step on the same channel, and that the unmapped-page flag only appears with a page write. The table and directed scenarios are needed for the values themselves. These include byte ordering, the reload that follows a high-byte write, readback arithmetic during a transfer, the wrap point, the scrambled page map and the doubled word-mode values. None of these can be stated without a known stimulus history.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam int REG_W = 16;

  typedef enum logic {
    SEL_ADDR = 1'b0,
    SEL_CNT  = 1'b1
  } reg_sel_e;

  // choose the byte addressed by the pointer
  function automatic logic [7:0] pick_byte(input logic [REG_W-1:0] v, input logic hi);
    return hi ? v[15:8] : v[7:0];
  endfunction

  // merge selected byte lanes of d into q
  function automatic logic [REG_W-1:0] merge_lanes(input logic [REG_W-1:0] q,
                                                   input logic [REG_W-1:0] d,
                                                   input logic [1:0]       mask);
    return {mask[1] ? d[15:8] : q[15:8], mask[0] ? d[7:0] : q[7:0]};
  endfunction

endpackage

// File: rtl/dma_ptr_ff.sv
module dma_ptr_ff (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic toggle,
  output logic ptr
);
  logic ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (clr)         ptr_d = 1'b0;
    else if (toggle) ptr_d = ~ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= 1'b0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/dma_page_map.sv
module dma_page_map #(
  parameter int CH_W = 2
) (
  input  logic [2:0]      off,
  output logic            hit,
  output logic [CH_W-1:0] ch
);
  always_comb begin
    hit = 1'b1;
    ch  = '0;
    unique case (off)
      3'd7:    ch = CH_W'(0);
      3'd3:    ch = CH_W'(1);
      3'd1:    ch = CH_W'(2);
      3'd2:    ch = CH_W'(3);
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/dma_chan_slot.sv
module dma_chan_slot
  import dma_chan_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int SH     = 0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ld_en,
  input  reg_sel_e                  ld_sel,
  input  logic [1:0]                ld_mask,
  input  logic [REG_W-1:0]          ld_data,
  input  logic                      reload,
  input  logic                      step,
  input  logic                      page_we,
  input  logic [PAGE_W-1:0]         page_d,
  output logic [REG_W-1:0]          base_cnt,
  output logic [REG_W+SH-1:0]       cur,
  output logic [REG_W+SH:0]         prog,
  output logic [PAGE_W-1:0]         page,
  output logic                      tc
);
  localparam int CUR_W = REG_W + SH;
  localparam int PRG_W = CUR_W + 1;
  localparam logic [PRG_W-1:0] UNIT = PRG_W'(1) << SH;

  logic [REG_W-1:0]  base_addr_q, base_addr_d, base_cnt_q, base_cnt_d;
  logic [CUR_W-1:0]  cur_q, cur_d;
  logic [PRG_W-1:0]  prog_q, prog_d, prog_inc, len;
  logic [PAGE_W-1:0] page_q;
  logic              tc_q, tc_d, wrap;
  logic              addr_en, cnt_en, prog_en;

  assign addr_en  = ld_en && (ld_sel == SEL_ADDR);
  assign cnt_en   = ld_en && (ld_sel == SEL_CNT);
  assign prog_en  = reload || step;
  assign len      = (PRG_W'(base_cnt_q) << SH) + UNIT;
  assign prog_inc = prog_q + UNIT;
  assign wrap     = (prog_inc == len);

  always_comb begin
    base_addr_d = merge_lanes(base_addr_q, ld_data, ld_mask);
    base_cnt_d  = merge_lanes(base_cnt_q, ld_data, ld_mask);
    cur_d       = CUR_W'(addr_en ? base_addr_d : base_addr_q) << SH;
    if (reload)    prog_d = '0;
    else if (wrap) prog_d = '0;
    else           prog_d = prog_inc;
    tc_d = step && !reload && wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      cur_q       <= '0;
      prog_q      <= '0;
      page_q      <= '0;
      tc_q        <= 1'b0;
    end else begin
      if (addr_en) base_addr_q <= base_addr_d;
      if (cnt_en)  base_cnt_q  <= base_cnt_d;
      if (reload)  cur_q       <= cur_d;
      if (prog_en) prog_q      <= prog_d;
      if (page_we) page_q      <= page_d;
      tc_q <= tc_d;
    end
  end

  assign base_cnt = base_cnt_q;
  assign cur      = cur_q;
  assign prog     = prog_q;
  assign page     = page_q;
  assign tc       = tc_q;
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int PAGE_W    = 8,
  parameter bit WORD_MODE = 1'b0,
  localparam int SH       = WORD_MODE ? 1 : 0,
  localparam int CH_W     = $clog2(NCH),
  localparam int PORT_W   = CH_W + 1 + SH,
  localparam int PHYS_W   = PAGE_W + REG_W,
  localparam int CUR_W    = REG_W + SH,
  localparam int PRG_W    = CUR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_wide,
  input  logic [PORT_W-1:0] reg_port,
  input  logic [REG_W-1:0]  wr_data,
  output logic [7:0]        rd_data,
  input  logic              ff_clr,
  input  logic              page_wr,
  input  logic [2:0]        page_off,
  output logic              page_bad,
  input  logic [NCH-1:0]    step,
  output logic [NCH-1:0]    tc,
  input  logic [CH_W-1:0]   sel_ch,
  output logic [PHYS_W-1:0] phys_addr,
  output logic [PRG_W-1:0]  xfer_len
);
  localparam logic [PRG_W-1:0] UNIT = PRG_W'(1) << SH;

  // reset: asynchronous assert, synchronous release
  logic rst_s1_q, rst_s2_q, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_core_n = rst_s2_q;

  // port decode
  logic            port_ok, acc_wr, acc_rd, byte_acc, ff_q;
  logic [CH_W-1:0] ch_idx;
  reg_sel_e        rsel;

  generate
    if (WORD_MODE) begin : g_word_dec
      assign port_ok = ~reg_port[0];
    end else begin : g_byte_dec
      assign port_ok = 1'b1;
    end
  endgenerate

  assign ch_idx   = reg_port[SH+1 +: CH_W];
  assign rsel     = reg_sel_e'(reg_port[SH]);
  assign acc_wr   = reg_wr && port_ok;
  assign acc_rd   = reg_rd && port_ok;
  assign byte_acc = acc_rd || (acc_wr && !reg_wide);

  dma_ptr_ff u_ptr (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .clr    (ff_clr),
    .toggle (byte_acc),
    .ptr    (ff_q)
  );

  logic [1:0]       wr_mask;
  logic [REG_W-1:0] ld_data;
  logic             reload_any;

  assign wr_mask    = reg_wide ? 2'b11 : (ff_q ? 2'b10 : 2'b01);
  assign ld_data    = reg_wide ? wr_data : {wr_data[7:0], wr_data[7:0]};
  assign reload_any = acc_wr && (reg_wide || ff_q);

  // page decode
  logic            pg_hit;
  logic [CH_W-1:0] pg_ch;

  dma_page_map #(.CH_W(CH_W)) u_pmap (
    .off (page_off),
    .hit (pg_hit),
    .ch  (pg_ch)
  );
  assign page_bad = page_wr && !pg_hit;

  // channel slots
  logic [REG_W-1:0]  bcnt_a [NCH];
  logic [CUR_W-1:0]  cur_a  [NCH];
  logic [PRG_W-1:0]  prog_a [NCH];
  logic [PAGE_W-1:0] page_a [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit_ch;
    assign hit_ch = (ch_idx == CH_W'(i));
    dma_chan_slot #(.PAGE_W(PAGE_W), .SH(SH)) u_slot (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .ld_en    (acc_wr && hit_ch),
      .ld_sel   (rsel),
      .ld_mask  (wr_mask),
      .ld_data  (ld_data),
      .reload   (reload_any && hit_ch),
      .step     (step[i]),
      .page_we  (page_wr && pg_hit && (pg_ch == CH_W'(i))),
      .page_d   (wr_data[PAGE_W-1:0]),
      .base_cnt (bcnt_a[i]),
      .cur      (cur_a[i]),
      .prog     (prog_a[i]),
      .page     (page_a[i]),
      .tc       (tc[i])
    );
  end

  // readback arithmetic
  logic [REG_W-1:0] addr_val, cnt_val;
  always_comb begin
    addr_val = REG_W'((PRG_W'(cur_a[ch_idx]) + prog_a[ch_idx]) >> SH);
    cnt_val  = REG_W'(((PRG_W'(bcnt_a[ch_idx]) << SH) - prog_a[ch_idx]) >> SH);
    rd_data  = 8'h00;
    if (acc_rd) rd_data = pick_byte((rsel == SEL_CNT) ? cnt_val : addr_val, ff_q);
  end

  // transfer view of selected channel
  assign phys_addr = {page_a[sel_ch], REG_W'(0)} | PHYS_W'(cur_a[sel_ch]);
  assign xfer_len  = (PRG_W'(bcnt_a[sel_ch]) << SH) + UNIT;
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ff,
  input logic           byte_acc,
  input logic           ff_clr,
  input logic [NCH-1:0] step,
  input logic [NCH-1:0] tc,
  input logic           page_wr,
  input logic           page_bad
);
  assert_ptr_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_acc && !ff_clr) |=> (ff != $past(ff)));

  assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_acc && !ff_clr) |=> $stable(ff));

  assert_ptr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ff_clr |=> (ff == 1'b0));

  assert_tc_after_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tc != '0) |-> ((tc & ~$past(step)) == '0));

  assert_page_bad_needs_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    page_bad |-> page_wr);
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.NCH(NCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .ff       (ff_q),
  .byte_acc (byte_acc),
  .ff_clr   (ff_clr),
  .step     (step),
  .tc       (tc),
  .page_wr  (page_wr),
  .page_bad (page_bad)
);

// File: tb/tb_dma_chan_regs.sv
module tb_dma_chan_regs;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        reg_wr, reg_rd, reg_wide, ff_clr, page_wr;
  logic [2:0]  reg_port, page_off;
  logic [15:0] wr_data;
  logic [3:0]  step, tc;
  logic [1:0]  sel_ch;
  logic [7:0]  rd_data;
  logic        page_bad;
  logic [23:0] phys_addr;
  logic [16:0] xfer_len;

  logic        w_reg_wr, w_reg_rd, w_reg_wide, w_ff_clr;
  logic [3:0]  w_reg_port, w_step, w_tc;
  logic [15:0] w_wr_data;
  logic [1:0]  w_sel_ch;
  logic [7:0]  w_rd_data;
  logic        w_page_bad;
  logic [23:0] w_phys;
  logic [17:0] w_len;

  dma_chan_regs dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wide(reg_wide),
    .reg_port(reg_port), .wr_data(wr_data), .rd_data(rd_data), .ff_clr(ff_clr),
    .page_wr(page_wr), .page_off(page_off), .page_bad(page_bad), .step(step), .tc(tc),
    .sel_ch(sel_ch), .phys_addr(phys_addr), .xfer_len(xfer_len)
  );

  dma_chan_regs #(.WORD_MODE(1'b1)) dut_w (
    .clk(clk), .rst_n(rst_n), .reg_wr(w_reg_wr), .reg_rd(w_reg_rd), .reg_wide(w_reg_wide),
    .reg_port(w_reg_port), .wr_data(w_wr_data), .rd_data(w_rd_data), .ff_clr(w_ff_clr),
    .page_wr(1'b0), .page_off(3'd0), .page_bad(w_page_bad), .step(w_step), .tc(w_tc),
    .sel_ch(w_sel_ch), .phys_addr(w_phys), .xfer_len(w_len)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // op: 0 = clear pointer, 1 = byte write, 2 = byte read
  task automatic bop(input logic [1:0] op, input logic [2:0] port, input logic [7:0] d,
                     output logic [7:0] rd);
    reg_port = port;
    wr_data  = {8'h00, d};
    ff_clr   = (op == 2'd0);
    reg_wr   = (op == 2'd1);
    reg_rd   = (op == 2'd2);
    #1 rd = rd_data;
    @(negedge clk);
    ff_clr = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
  endtask

  task automatic wop(input logic [1:0] op, input logic [3:0] port, input logic [15:0] d,
                     input logic wide, output logic [7:0] rd);
    w_reg_port = port;
    w_wr_data  = d;
    w_reg_wide = wide;
    w_ff_clr   = (op == 2'd0);
    w_reg_wr   = (op == 2'd1);
    w_reg_rd   = (op == 2'd2);
    #1 rd = w_rd_data;
    @(negedge clk);
    w_ff_clr = 1'b0; w_reg_wr = 1'b0; w_reg_rd = 1'b0; w_reg_wide = 1'b0;
  endtask

  task automatic pwr(input logic [2:0] off, input logic [7:0] d, input logic exp_bad);
    page_off = off;
    wr_data  = {8'h00, d};
    page_wr  = 1'b1;
    #1 check("R7 page_bad", {31'd0, page_bad}, {31'd0, exp_bad});
    @(negedge clk);
    page_wr = 1'b0;
  endtask

  // {op, port, data, expected read byte}
  localparam int NV = 18;
  localparam logic [20:0] VEC [NV] = '{
    {2'd0, 3'd0, 8'h00, 8'h00},  // clear pointer (R6)
    {2'd1, 3'd0, 8'h34, 8'h00},  // ch0 address low (R2, R3)
    {2'd1, 3'd0, 8'h12, 8'h00},  // ch0 address high, reload (R4)
    {2'd1, 3'd1, 8'h05, 8'h00},  // ch0 count low
    {2'd1, 3'd1, 8'h00, 8'h00},  // ch0 count high
    {2'd2, 3'd0, 8'h00, 8'h34},  // R5 address low
    {2'd2, 3'd0, 8'h00, 8'h12},  // R5 address high
    {2'd2, 3'd1, 8'h00, 8'h05},  // R5 count low
    {2'd2, 3'd1, 8'h00, 8'h00},  // R5 count high
    {2'd1, 3'd6, 8'hCD, 8'h00},  // ch3 address low (R2)
    {2'd1, 3'd6, 8'hAB, 8'h00},  // ch3 address high
    {2'd2, 3'd6, 8'h00, 8'hCD},  // ch3 readback low
    {2'd2, 3'd6, 8'h00, 8'hAB},  // ch3 readback high
    {2'd2, 3'd0, 8'h00, 8'h34},  // ch0 untouched, pointer now 1
    {2'd0, 3'd0, 8'h00, 8'h00},  // R6 clear mid-sequence
    {2'd2, 3'd0, 8'h00, 8'h34},  // low byte again after clear
    {2'd2, 3'd0, 8'h00, 8'h12},
    {2'd2, 3'd7, 8'h00, 8'h00}   // ch3 count low
  };

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    rst_n = 1'b0;
    reg_wr = 0; reg_rd = 0; reg_wide = 0; ff_clr = 0; page_wr = 0;
    reg_port = 0; page_off = 0; wr_data = 0; step = 0; sel_ch = 0;
    w_reg_wr = 0; w_reg_rd = 0; w_reg_wide = 0; w_ff_clr = 0;
    w_reg_port = 0; w_wr_data = 0; w_step = 0; w_sel_ch = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 phys_addr", {8'd0, phys_addr}, 32'd0);
    check("R1 xfer_len", {15'd0, xfer_len}, 32'd1);
    check("R1 tc", {28'd0, tc}, 32'd0);
    check("R1 rd_data idle (R5)", {24'd0, rd_data}, 32'd0);
    bop(2'd2, 3'd0, 8'h00, rd);
    check("R1 address read", {24'd0, rd}, 32'd0);
    bop(2'd2, 3'd1, 8'h00, rd);
    check("R1 count read", {24'd0, rd}, 32'd0);

    // table walk: R2 R3 R4 R5 R6
    for (int k = 0; k < NV; k++) begin
      bop(VEC[k][20:19], VEC[k][18:16], VEC[k][15:8], rd);
      if (VEC[k][20:19] == 2'd2)
        check($sformatf("R2/R3/R5 vector %0d", k), {24'd0, rd}, {24'd0, VEC[k][7:0]});
    end

    // R10 progress and readback during transfer
    bop(2'd0, 3'd0, 8'h00, rd);
    step = 4'b0001;
    repeat (2) @(negedge clk);
    step = 4'b0000;
    bop(2'd2, 3'd0, 8'h00, rd);
    check("R5 address plus progress low", {24'd0, rd}, 32'h36);
    bop(2'd2, 3'd0, 8'h00, rd);
    check("R5 address plus progress high", {24'd0, rd}, 32'h12);
    bop(2'd2, 3'd1, 8'h00, rd);
    check("R5 remaining count low", {24'd0, rd}, 32'h03);
    bop(2'd2, 3'd1, 8'h00, rd);
    check("R5 remaining count high", {24'd0, rd}, 32'h00);
    for (int i = 0; i < 3; i++) begin
      step = 4'b0001;
      @(negedge clk);
      step = 4'b0000;
      check("R10 no tc before length", {28'd0, tc}, 32'd0);
    end
    step = 4'b0001;
    @(negedge clk);
    step = 4'b0000;
    check("R10 tc at wrap", {28'd0, tc}, 32'd1);
    @(negedge clk);
    check("R10 tc single cycle", {28'd0, tc}, 32'd0);
    bop(2'd0, 3'd0, 8'h00, rd);
    bop(2'd2, 3'd0, 8'h00, rd);
    check("R10 progress wrapped to 0", {24'd0, rd}, 32'h34);

    // R4 reload clears progress, reload beats step
    step = 4'b0001;
    repeat (2) @(negedge clk);
    step = 4'b0000;
    bop(2'd0, 3'd0, 8'h00, rd);
    bop(2'd1, 3'd1, 8'h05, rd);
    step = 4'b0001;
    bop(2'd1, 3'd1, 8'h00, rd);
    step = 4'b0000;
    bop(2'd2, 3'd0, 8'h00, rd);
    check("R4 reload cleared progress", {24'd0, rd}, 32'h34);
    bop(2'd2, 3'd0, 8'h00, rd);
    bop(2'd2, 3'd1, 8'h00, rd);
    check("R4 count after reload", {24'd0, rd}, 32'h05);
    bop(2'd0, 3'd0, 8'h00, rd);

    // R7 page map and R8 physical address
    pwr(3'd1, 8'h7A, 1'b0);
    pwr(3'd7, 8'h11, 1'b0);
    pwr(3'd3, 8'h22, 1'b0);
    pwr(3'd2, 8'h33, 1'b0);
    pwr(3'd5, 8'hFF, 1'b1);
    pwr(3'd0, 8'hEE, 1'b1);
    sel_ch = 2'd0; #1 check("R8 phys ch0", {8'd0, phys_addr}, 32'h111234);
    sel_ch = 2'd1; #1 check("R7 phys ch1", {8'd0, phys_addr}, 32'h220000);
    sel_ch = 2'd2; #1 check("R7 phys ch2", {8'd0, phys_addr}, 32'h7A0000);
    sel_ch = 2'd3; #1 check("R8 phys ch3", {8'd0, phys_addr}, 32'h33ABCD);

    // R9 transfer length
    sel_ch = 2'd0; #1 check("R9 length ch0", {15'd0, xfer_len}, 32'd6);
    sel_ch = 2'd3; #1 check("R9 length ch3", {15'd0, xfer_len}, 32'd1);
    @(negedge clk);

    // R3 wide write keeps pointer
    reg_wide = 1'b1;
    bop(2'd1, 3'd2, 8'h00, rd);
    reg_wide = 1'b0;
    reg_port = 3'd2; wr_data = 16'hBEEF; reg_wide = 1'b1; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wide = 1'b0;
    bop(2'd2, 3'd2, 8'h00, rd);
    check("R3 wide write low byte, pointer kept", {24'd0, rd}, 32'hEF);
    bop(2'd2, 3'd2, 8'h00, rd);
    check("R3 wide write high byte", {24'd0, rd}, 32'hBE);
    sel_ch = 2'd1; #1 check("R4 wide write reload", {8'd0, phys_addr}, 32'h22BEEF);

    // R11 word mode
    wop(2'd1, 4'd4, 16'h1000, 1'b1, rd);
    wop(2'd1, 4'd6, 16'h0003, 1'b1, rd);
    w_sel_ch = 2'd1;
    #1 check("R11 word phys", {8'd0, w_phys}, 32'h002000);
    check("R11 word length", {14'd0, w_len}, 32'd8);
    @(negedge clk);
    w_step = 4'b0010;
    @(negedge clk);
    w_step = 4'b0000;
    wop(2'd2, 4'd4, 16'h0, 1'b0, rd);
    check("R11 word address low", {24'd0, rd}, 32'h01);
    wop(2'd2, 4'd4, 16'h0, 1'b0, rd);
    check("R11 word address high", {24'd0, rd}, 32'h10);
    wop(2'd2, 4'd6, 16'h0, 1'b0, rd);
    check("R11 word count low", {24'd0, rd}, 32'h02);
    wop(2'd2, 4'd6, 16'h0, 1'b0, rd);
    wop(2'd1, 4'd5, 16'h0055, 1'b0, rd);
    wop(2'd2, 4'd4, 16'h0, 1'b0, rd);
    check("R11 odd port ignored", {24'd0, rd}, 32'h01);
    #1 check("R11 phys after odd write", {8'd0, w_phys}, 32'h002000);

    finish_run();
  end
endmodule